// File: doc/BRIEF.md
# Odd-Sum Integer Square Root

This unit returns the floor of the square root of an unsigned operand. The root is found from the fact that the sum of the first n odd numbers is n squared. A running total starts at one and the odd step starts at three. The step is added to the total and then grows by two, again and again, until the total passes the operand. At that point, half the step minus one is the root.

All the summation steps are unrolled into combinational logic. Each step compares its partial total with the operand, and a small control module turns the comparison flags into a one-hot select of the first stage that overshoots. A datapath picks the odd step at that stage and forms the root. The root is held in a register loaded on the falling clock edge, so a new operand gives its root at the next falling edge. The block has no reset and no handshake. The design does not use division, power or modulo operators.

Top module: `isqrt_odd_sum`

## Requirements
- R1: For every 10-bit unsigned operand value 0 to 1023, the 5-bit root output equals the largest r with r*r not greater than the operand.
- R2: Operand 0 gives root 0, because the first partial total of 1 already exceeds it.
- R3: Operands 1, 2 and 3 give root 1.
- R4: Operands 4 to 8 give root 2, and operands 9 to 15 give root 3.
- R5: The largest operand 1023 gives root 31. The final partial total of 1024 and step of 65 fit in the 11-bit working width.
- R6: A perfect square k*k gives k, and k*k-1 gives k-1, for every k from 1 to 31.
- R7: The root output changes only on a falling clock edge. A new operand applied after a rising edge leaves the output unchanged until the next falling edge, and it shows the new root after that edge.
- R8: For any operand, exactly one summation stage is selected as the exit point, and the last stage always overshoots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the root register loads on its falling edge |
| operand | input | 10 | Unsigned value whose square root is taken |
| root | output | 5 | Registered floor of the square root |

## Verification
Each root is due at the first falling edge after its operand is applied, with one register on the path. The bench changes the operand just after a rising edge. It first confirms that the output still holds the previous root before the falling edge. It then samples the new root one nanosecond after that falling edge, against a reference computed by a bench function. An exhaustive sweep, directed square boundaries and seeded random operands all use this same timing.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  localparam int IN_W   = 10;
  localparam int ROOT_W = (IN_W + 1) / 2;
  localparam int WORK_W = 2 * ROOT_W + 1;
  localparam int NUM_ST = 1 << ROOT_W;

  typedef struct packed {
    logic [NUM_ST-1:0] exitSel;
  } isqrtStrobes_t;
endpackage

// File: rtl/isqrt_stage.sv
module isqrt_stage #(
  parameter int W = 11
) (
  input  logic [W-1:0] sumIn,
  input  logic [W-1:0] stepIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] stepOut
);
  assign sumOut  = sumIn + stepIn;
  assign stepOut = stepIn + W'(2);
endmodule

// File: rtl/isqrt_control.sv
module isqrt_control
  import isqrt_pkg::*;
(
  input  logic [NUM_ST-1:0] overFlag,
  output isqrtStrobes_t     strobes
);
  always_comb begin
    strobes.exitSel[0] = overFlag[0];
    for (int s = 1; s < NUM_ST; s++)
      strobes.exitSel[s] = overFlag[s] & ~overFlag[s-1];
  end

  always_comb begin
    if (!$isunknown(overFlag)) begin
      a_r8_single_exit: assert ($onehot(strobes.exitSel))
        else $error("exit select not one-hot");
      a_r8_last_over: assert (overFlag[NUM_ST-1])
        else $error("final stage did not overshoot");
    end
  end
endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath
  import isqrt_pkg::*;
(
  input  logic              clk,
  input  logic [IN_W-1:0]   operand,
  input  isqrtStrobes_t     strobes,
  output logic [NUM_ST-1:0] overFlag,
  output logic [ROOT_W-1:0] root
);
  logic [WORK_W-1:0] sumChain  [NUM_ST];
  logic [WORK_W-1:0] stepChain [NUM_ST];
  logic [WORK_W-1:0] opWide;
  logic [WORK_W-1:0] stepPick;
  logic [WORK_W-1:0] halfStep;
  logic [ROOT_W-1:0] rootNext;

  assign opWide       = WORK_W'(operand);
  assign sumChain[0]  = WORK_W'(1);
  assign stepChain[0] = WORK_W'(3);

  for (genvar s = 1; s < NUM_ST; s++) begin : gStage
    isqrt_stage #(.W(WORK_W)) uStage (
      .sumIn  (sumChain[s-1]),
      .stepIn (stepChain[s-1]),
      .sumOut (sumChain[s]),
      .stepOut(stepChain[s])
    );
  end

  for (genvar s = 0; s < NUM_ST; s++) begin : gCmp
    assign overFlag[s] = sumChain[s] > opWide;
  end

  always_comb begin
    stepPick = '0;
    for (int s = 0; s < NUM_ST; s++)
      stepPick = stepPick | (stepChain[s] & {WORK_W{strobes.exitSel[s]}});
  end

  assign halfStep = stepPick >> 1;
  assign rootNext = ROOT_W'(halfStep - WORK_W'(1));

  always_ff @(negedge clk) root <= rootNext;

  always_comb begin
    if (!$isunknown({operand, strobes})) begin
      a_r1_root_low: assert (32'(rootNext) * 32'(rootNext) <= 32'(operand))
        else $error("root too large");
      a_r1_root_high: assert ((32'(rootNext) + 1) * (32'(rootNext) + 1) > 32'(operand))
        else $error("root too small");
      a_r5_step_odd: assert (stepPick[0])
        else $error("selected step is even");
    end
  end
endmodule

// File: rtl/isqrt_odd_sum.sv
module isqrt_odd_sum
  import isqrt_pkg::*;
(
  input  logic             clk,
  input  logic [IN_W-1:0]  operand,
  output logic [ROOT_W-1:0] root
);
  logic [NUM_ST-1:0] overFlag;
  isqrtStrobes_t     strobes;

  isqrt_control uCtrl (
    .overFlag(overFlag),
    .strobes (strobes)
  );

  isqrt_datapath uData (
    .clk     (clk),
    .operand (operand),
    .strobes (strobes),
    .overFlag(overFlag),
    .root    (root)
  );
endmodule

// File: tb/tb_isqrt_odd_sum.sv
`timescale 1ns/1ps
module tb_isqrt_odd_sum;
  logic       clk = 1'b0;
  logic [9:0] operand = '0;
  logic [4:0] root;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  isqrt_odd_sum dut (.clk(clk), .operand(operand), .root(root));

  always #4 clk = ~clk;

  function automatic int refRoot(int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: operand=%0d actual=%0d expected=%0d", req, operand, act, exp);
    end
  endtask

  task automatic apply(string req, int v);
    int prev;
    @(posedge clk); #1;
    prev = int'(root);
    operand = 10'(v);
    #1 check("R7", int'(root), prev);
    @(negedge clk); #1;
    check(req, int'(root), refRoot(v));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    apply("R2", 0);
    for (int v = 1; v <= 3; v++) apply("R3", v);
    for (int v = 4; v <= 15; v++) apply("R4", v);
    apply("R5", 1023);
    for (int k = 1; k <= 31; k++) begin
      apply("R6", k * k);
      apply("R6", k * k - 1);
    end
    apply("R5", 1023);
    apply("R2", 0);
    for (int v = 0; v < 1024; v++) apply("R1", v);
    for (int n = 0; n < 400; n++) apply("R1", int'($urandom_range(1023, 0)));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule